// File: doc/BRIEF.md
# Interval Timer with Falling-Edge Event Counting

This block is a 16-bit down-counter written and read one byte at a time over a small host port. A two-bit mode input picks the decrement source. In interval mode the count drops by one on every system clock. In pulse mode it drops by one for each high-to-low transition on an external pin. The pin passes through a synchroniser before its edges are detected. In rate mode the low byte works as a self-reloading divider. This mode is meant to pace a serial shifter.

The host first writes a byte into a holding latch for the low half. A second write supplies the high half and loads the whole counter in one step. That write also clears the interrupt flag and arms it again. The flag goes high once, when an armed count steps from one to zero. The counter then keeps falling through the wrap, so software can read how long ago the timeout happened. No second interrupt follows until the counter is loaded again. A one-cycle tick marks every borrow out of the low byte.

Top module: `tmr_event_counter`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, the count is 0x0000, `irq_o` is 0, `tick_o` is 0 and `rdata_o` is 0.
- R2: Mode code 0 (interval) decrements the count by one on every clock edge. The count wraps from 0x0000 to 0xFFFF.
- R3: Mode code 1 (pulse) decrements the count once per falling edge of `cnt_pin_i`. The new value shows after the third rising clock edge that follows the pin falling. Rising edges and steady levels leave the count unchanged.
- R4: After a load, the first decrement from 0x0001 to 0x0000 sets `irq_o`. The count then continues to 0xFFFF and below. `irq_o` is not set again until the next load, even when the count passes through zero again.
- R5: A write with `addr_i`=0 stores `wdata_i` in the low-byte latch and leaves the count alone. A write with `addr_i`=1 loads the count with {`wdata_i`, latch}, clears `irq_o` and arms the interrupt. On that edge the load takes priority over any decrement.
- R6: `rdata_o` shows count bits 7:0 when `addr_i`=0 and bits 15:8 when `addr_i`=1, with no clock delay. A read strobe with `addr_i`=0 clears `irq_o` at the next edge, unless the flag is being set on that same edge.
- R7: `tick_o` is high for exactly the one cycle after an edge at which the count decremented while its low byte was 0x00.
- R8: Mode code 2 (rate) decrements on every clock. When the low byte is 0x00, that edge reloads it from the latch and leaves the high byte unchanged. With latch value L this gives a tick every L+1 cycles.
- R9: Mode code 3 behaves exactly like interval mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 2 | Decrement source: 0 interval, 1 pulse, 2 rate, 3 interval |
| cnt_pin_i | input | 1 | External event pin, asynchronous |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe (clears the flag when reading the low byte) |
| addr_i | input | 1 | Byte select: 0 low, 1 high |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Selected count byte |
| irq_o | output | 1 | Interrupt flag |
| tick_o | output | 1 | One-cycle low-byte borrow pulse |

## Verification
A write or read strobe takes effect at the next rising edge. From that edge the count, the flag and the tick move together, because all three are registers updated in the same state word. The one exception is a pin fall, which reaches the count only on the third edge after the pin changes. `rdata_o` follows `addr_i` with no clock. The reference model in the bench therefore advances at each rising edge. Its outputs are compared a quarter period later, while stimulus changes only on falling edges. The directed checks sample on falling edges at cycle counts taken from these latencies, including the two edges at which a pin fall must not yet show.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [1:0] {
        MODE_INTERVAL = 2'b00,
        MODE_PULSE    = 2'b01,
        MODE_RATE     = 2'b10,
        MODE_SPARE    = 2'b11
    } tmr_mode_e;

    localparam logic ADDR_LOW  = 1'b0;
    localparam logic ADDR_HIGH = 1'b1;

endpackage

// File: rtl/tmr_pin_sync.sv
module tmr_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic fall_o
);

    logic last_q;
    logic synced;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            logic stage_q;
            if (i == 0) begin : g_head
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q <= 1'b0;
                    else        stage_q <= pin_i;
                end
            end else begin : g_tail
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q <= 1'b0;
                    else        stage_q <= g_stage[i-1].stage_q;
                end
            end
        end
    endgenerate

    assign synced = g_stage[STAGES-1].stage_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= synced;
    end

    // high while the synchronised level has just gone from 1 to 0
    assign fall_o = last_q & ~synced;

endmodule

// File: rtl/tmr_count_step.sv
module tmr_count_step
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0]  count_i,
    input  logic [BYTE_W-1:0] latch_i,
    input  logic              reload_low_i,
    output logic [CNT_W-1:0]  next_o,
    output logic              low_wrap_o,
    output logic              reach_zero_o
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    always_comb begin
        low_wrap_o   = (count_i[BYTE_W-1:0] == '0);
        reach_zero_o = (count_i == ONE);
        if (reload_low_i && low_wrap_o) begin
            next_o = {count_i[CNT_W-1:BYTE_W], latch_i};
        end else begin
            next_o = count_i - ONE;
        end
    end

endmodule

// File: rtl/tmr_host_port.sv
module tmr_host_port
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              addr_i,
    input  logic [CNT_W-1:0]  count_i,
    output logic              latch_we_o,
    output logic              load_o,
    output logic              rd_low_o,
    output logic [BYTE_W-1:0] rdata_o
);

    localparam int HI_W = CNT_W - BYTE_W;

    logic [BYTE_W-1:0] hi_byte;

    always_comb begin
        latch_we_o = wr_en_i && (addr_i == ADDR_LOW);
        load_o     = wr_en_i && (addr_i == ADDR_HIGH);
        rd_low_o   = rd_en_i && (addr_i == ADDR_LOW);

        hi_byte             = '0;
        hi_byte[HI_W-1:0]   = count_i[CNT_W-1:BYTE_W];
        rdata_o = (addr_i == ADDR_LOW) ? count_i[BYTE_W-1:0] : hi_byte;
    end

endmodule

// File: rtl/tmr_event_counter.sv
module tmr_event_counter
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              cnt_pin_i,
    input  logic              wr_en_i,
    input  logic              rd_en_i,
    input  logic              addr_i,
    input  logic [7:0]        wdata_i,
    output logic [7:0]        rdata_o,
    output logic              irq_o,
    output logic              tick_o
);

    localparam int HI_W = CNT_W - BYTE_W;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [BYTE_W-1:0] latch;
        logic              flag;
        logic              armed;
        logic              tick;
    } tmr_state_t;

    tmr_state_t st_d, st_q;

    logic              pin_fall;
    logic              latch_we, load_hi, rd_low;
    logic              dec_en, rate_sel, irq_set;
    logic [CNT_W-1:0]  step_next;
    logic              low_wrap, reach_zero;
    logic [CNT_W-1:0]  count_q;
    logic [BYTE_W-1:0] latch_q;
    tmr_mode_e         mode;

    assign mode     = tmr_mode_e'(mode_i);
    assign count_q  = st_q.count;
    assign latch_q  = st_q.latch;

    tmr_pin_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (cnt_pin_i),
        .fall_o (pin_fall)
    );

    tmr_host_port #(
        .CNT_W (CNT_W)
    ) u_port (
        .wr_en_i    (wr_en_i),
        .rd_en_i    (rd_en_i),
        .addr_i     (addr_i),
        .count_i    (st_q.count),
        .latch_we_o (latch_we),
        .load_o     (load_hi),
        .rd_low_o   (rd_low),
        .rdata_o    (rdata_o)
    );

    tmr_count_step #(
        .CNT_W (CNT_W)
    ) u_step (
        .count_i      (st_q.count),
        .latch_i      (st_q.latch),
        .reload_low_i (rate_sel),
        .next_o       (step_next),
        .low_wrap_o   (low_wrap),
        .reach_zero_o (reach_zero)
    );

    always_comb begin
        rate_sel = (mode == MODE_RATE);
        dec_en   = (mode == MODE_PULSE) ? pin_fall : 1'b1;
        irq_set  = !load_hi && dec_en && reach_zero && st_q.armed;

        st_d      = st_q;
        st_d.tick = 1'b0;

        if (load_hi) begin
            st_d.count = {wdata_i[HI_W-1:0], st_q.latch};
            st_d.armed = 1'b1;
        end else if (dec_en) begin
            st_d.count = step_next;
            st_d.tick  = low_wrap;
            if (irq_set) st_d.armed = 1'b0;
        end

        if (load_hi)      st_d.flag = 1'b0;
        else if (irq_set) st_d.flag = 1'b1;
        else if (rd_low)  st_d.flag = 1'b0;

        if (latch_we) st_d.latch = wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq_o  = st_q.flag;
    assign tick_o = st_q.tick;

endmodule

// File: rtl/tmr_event_counter_chk.sv
module tmr_event_counter_chk
    import tmr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              load,
    input logic              rd_low,
    input logic              fall,
    input logic [CNT_W-1:0]  count,
    input logic [BYTE_W-1:0] latch,
    input logic              irq_o,
    input logic              tick_o
);

    logic loaded_ck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     loaded_ck <= 1'b0;
        else if (load)  loaded_ck <= 1'b1;
        else if (irq_o) loaded_ck <= 1'b0;
    end

    // R2, R9: clock-driven modes step by one each edge
    a_r2_interval_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_i == MODE_INTERVAL || mode_i == MODE_SPARE) && !load)
        |=> count == $past(count) - CNT_W'(1));

    // R3: pulse mode holds without a detected fall
    a_r3_pulse_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_PULSE && !fall && !load) |=> $stable(count));

    // R4: a rising flag needs a load since the previous one
    a_r4_irq_once: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> loaded_ck);

    // R5: load clears the flag
    a_r5_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !irq_o);

    // R6: low-byte read clears the flag when no set is possible
    a_r6_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_low && !load && count != CNT_W'(1)) |=> !irq_o);

    // R8, R7: rate-mode low byte reloads with a tick
    a_r8_rate_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == MODE_RATE && !load && count[BYTE_W-1:0] == '0)
        |=> (count[BYTE_W-1:0] == $past(latch)) && tick_o);

endmodule

bind tmr_event_counter tmr_event_counter_chk #(
    .CNT_W (CNT_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i),
    .load   (load_hi),
    .rd_low (rd_low),
    .fall   (pin_fall),
    .count  (count_q),
    .latch  (latch_q),
    .irq_o  (irq_o),
    .tick_o (tick_o)
);

// File: tb/sim_tmr_event_counter.sv
`timescale 1ns/1ps
module sim_tmr_event_counter;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode_i = 2'd0;
    logic       cnt_pin_i = 1'b1;
    logic       wr_en_i = 1'b0;
    logic       rd_en_i = 1'b0;
    logic       addr_i = 1'b0;
    logic [7:0] wdata_i = 8'h00;
    logic [7:0] rdata_o;
    logic       irq_o;
    logic       tick_o;

    int    n_checks = 0;
    int    n_fails  = 0;
    string cur_req  = "R1";

    // reference model state
    int m_count = 0, m_latch = 0, m_flag = 0, m_armed = 0, m_tick = 0;
    int m_s1 = 0, m_s2 = 0, m_s3 = 0;

    always #10 clk = ~clk;

    tmr_event_counter u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_i    (mode_i),
        .cnt_pin_i (cnt_pin_i),
        .wr_en_i   (wr_en_i),
        .rd_en_i   (rd_en_i),
        .addr_i    (addr_i),
        .wdata_i   (wdata_i),
        .rdata_o   (rdata_o),
        .irq_o     (irq_o),
        .tick_o    (tick_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model: advance at each edge, compare a quarter period later
    always @(posedge clk) begin
        if (!rst_n) begin
            m_count = 0; m_latch = 0; m_flag = 0; m_armed = 0; m_tick = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0;
        end else begin
            bit fall, dec, load, setf;
            int exp_byte;
            fall = (m_s3 == 1) && (m_s2 == 0);
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = cnt_pin_i;
            dec  = (mode_i == 2'd1) ? fall : 1'b1;
            load = wr_en_i && addr_i;
            setf = 1'b0;
            if (load) begin
                m_count = (int'(wdata_i) << 8) | m_latch;
                m_armed = 1; m_tick = 0;
            end else if (dec) begin
                m_tick = ((m_count & 255) == 0);
                if (m_count == 1 && m_armed == 1) begin setf = 1'b1; m_armed = 0; end
                if (mode_i == 2'd2 && (m_count & 255) == 0)
                    m_count = (m_count & 32'hFF00) | m_latch;
                else
                    m_count = (m_count - 1) & 32'hFFFF;
            end else begin
                m_tick = 0;
            end
            if (load)                       m_flag = 0;
            else if (setf)                  m_flag = 1;
            else if (rd_en_i && !addr_i)    m_flag = 0;
            if (wr_en_i && !addr_i) m_latch = wdata_i;
            #5;
            exp_byte = addr_i ? ((m_count >> 8) & 255) : (m_count & 255);
            n_checks++;
            if (rdata_o !== 8'(exp_byte) || irq_o !== 1'(m_flag) || tick_o !== 1'(m_tick)) begin
                n_fails++;
                $display("FAIL %s model: actual rdata=%0h irq=%0b tick=%0b expected rdata=%0h irq=%0b tick=%0b at %0t",
                         cur_req, rdata_o, irq_o, tick_o, exp_byte, m_flag, m_tick, $time);
            end
        end
    end

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk); wr_en_i = 1'b1; addr_i = a; wdata_i = d;
        @(negedge clk); wr_en_i = 1'b0; addr_i = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic peek(input logic a, output logic [7:0] v);
        addr_i = a; #2; v = rdata_o; addr_i = 1'b0; #1;
    endtask

    task automatic pin_pulse();
        @(negedge clk); cnt_pin_i = 1'b0;
        idle(4);
        cnt_pin_i = 1'b1;
        idle(4);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog expired in %s", cur_req);
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

    initial begin
        logic [7:0] v;
        // R1: reset state
        idle(3);
        check("R1 rdata", rdata_o, 0);
        check("R1 irq", irq_o, 0);
        check("R1 tick", tick_o, 0);
        rst_n = 1'b1;

        // R2/R4/R5: interval load of 5
        cur_req = "R2";
        idle(3);
        wr(1'b0, 8'h05);
        wr(1'b1, 8'h00);
        peek(1'b0, v); check("R5 load low", v, 8'h05);
        check("R5 irq cleared", irq_o, 0);
        idle(4);
        peek(1'b0, v); check("R2 count 1", v, 8'h01);
        check("R4 not yet", irq_o, 0);
        idle(1);
        peek(1'b0, v); check("R4 zero", v, 8'h00);
        check("R4 irq set", irq_o, 1);
        idle(1);
        peek(1'b0, v); check("R4 wrap low", v, 8'hFF);
        peek(1'b1, v); check("R6 high read", v, 8'hFF);
        check("R7 tick on borrow", tick_o, 1);
        idle(1);
        check("R7 tick single", tick_o, 0);

        // R6: read low clears flag
        cur_req = "R6";
        @(negedge clk); rd_en_i = 1'b1; addr_i = 1'b0;
        @(negedge clk); rd_en_i = 1'b0;
        #2 check("R6 read clears", irq_o, 0);

        // R4: full wrap without reload gives no second interrupt
        cur_req = "R4";
        idle(65545);
        check("R4 no second irq", irq_o, 0);

        // R5: latch then load
        cur_req = "R5";
        wr(1'b0, 8'h34);
        wr(1'b1, 8'h12);
        peek(1'b0, v); check("R5 low", v, 8'h34);
        peek(1'b1, v); check("R5 high", v, 8'h12);
        wr(1'b0, 8'h99);
        peek(1'b0, v); check("R5 latch write leaves count", v, 8'h33 - 8'h01);

        // R3: pulse mode
        cur_req = "R3";
        @(negedge clk); mode_i = 2'd1;
        wr(1'b0, 8'h03);
        wr(1'b1, 8'h00);
        idle(5);
        peek(1'b0, v); check("R3 steady level", v, 8'h03);
        @(negedge clk); cnt_pin_i = 1'b0;
        idle(2);
        peek(1'b0, v); check("R3 not before third edge", v, 8'h03);
        idle(1);
        peek(1'b0, v); check("R3 one fall one step", v, 8'h02);
        cnt_pin_i = 1'b1;
        idle(6);
        peek(1'b0, v); check("R3 rise no effect", v, 8'h02);
        pin_pulse();
        pin_pulse();
        peek(1'b0, v); check("R4 pulse zero", v, 8'h00);
        check("R4 pulse irq", irq_o, 1);
        pin_pulse();
        peek(1'b1, v); check("R4 pulse wrap", v, 8'hFF);

        // R8: rate mode
        cur_req = "R8";
        @(negedge clk); mode_i = 2'd2;
        wr(1'b0, 8'h03);
        wr(1'b1, 8'h12);
        idle(3);
        peek(1'b0, v); check("R8 low at zero", v, 8'h00);
        check("R7 no tick yet", tick_o, 0);
        idle(1);
        peek(1'b0, v); check("R8 reload", v, 8'h03);
        peek(1'b1, v); check("R8 high kept", v, 8'h12);
        check("R7 tick on reload", tick_o, 1);
        idle(40);
        peek(1'b1, v); check("R8 high steady", v, 8'h12);

        // R9: spare code counts like interval
        cur_req = "R9";
        @(negedge clk); mode_i = 2'd3;
        wr(1'b0, 8'h02);
        wr(1'b1, 8'h00);
        idle(2);
        check("R9 irq after two clocks", irq_o, 1);
        idle(5);

        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end

endmodule